// File: doc/BRIEF.md
# Freezable Binary Clock Divider

This block divides one input clock by two, four and eight. A single synchronous 3-bit counter advances on rising edges of the input clock, and its three bits drive the three outputs directly. All three outputs therefore change only at the same rising edges and stay in a fixed phase relation. They show no decode glitches.

Two controls act on the counter, and both are captured on the falling edge of the clock. A freeze request stops the counter at the next rising edge and keeps its value. When the request is withdrawn, counting continues from the held value. The master reset clears the counter on any rising edge at which it is high. Its release then passes through a short falling-edge pipeline. As a result, the first output toggle after release comes on the second rising edge if the release happens while the clock is high. It comes on the third rising edge if the release happens while the clock is low.

Top module: `freeze_div`

## Requirements
- R1: While running, the count goes up by one modulo 8 on every rising edge. The outputs q0, q1 and q2 are count bits 0, 1 and 2, so their periods are 2, 4 and 8 input cycles.
- R2: q1 changes only on a rising edge where q0 falls from 1 to 0. q2 changes only on a rising edge where q1 falls from 1 to 0.
- R3: If en is high at a falling edge, the count does not change at the rising edge that follows.
- R4: While en stays high, q0, q1 and q2 hold their levels for any number of cycles.
- R5: If en is low at a falling edge after a freeze, the count at the next rising edge is the held value plus one, modulo 8.
- R6: At any rising edge where mr is high, the count becomes zero, so q0, q1 and q2 all read 0.
- R7: If mr goes low while clk is high, q0 first rises at the second rising edge after the release.
- R8: If mr goes low while clk is low, q0 first rises at the third rising edge after the release.
- R9: A high en does not affect the release sequence. If en is still high when the release sequence completes, the count stays 0 until en is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| mr | input | 1 | Master reset, active high, clears the divider |
| en | input | 1 | Freeze request, active high, sampled on falling edges |
| q0 | output | 1 | Input clock divided by 2 |
| q1 | output | 1 | Input clock divided by 4 |
| q2 | output | 1 | Input clock divided by 8 |

## Verification
The bench times the reset release at both clock phases and counts rising edges until q0 first rises. A design that samples the release on the wrong edge, or has one stage too few or too many, shows a latency off by one for at least one of the two phases. Freeze and resume are checked against a held snapshot and against snapshot plus one. This catches a design that slips a count on entry or loses a count on exit. Period measurements on all three outputs, together with a per-cycle model comparison, catch a wrong bit mapping or a divider that fails to wrap. A freeze request held through the reset release catches a design that lets the release pipeline override the freeze.

// File: rtl/freeze_div_pkg.sv
// Package: shared sizes for the freezable divider.
// Assumes the counter width equals the number of divided outputs.
package freeze_div_pkg;
    localparam int unsigned DIV_W       = 3;   // outputs at /2, /4, /8
    localparam int unsigned RLS_STAGES  = 2;   // falling-edge release stages
    typedef logic [DIV_W-1:0] div_cnt_t;
endpackage

// File: rtl/freeze_div_ctl.sv
// Module: falling-edge control capture.
// Captures the freeze request and re-times the reset release through a
// shift chain clocked on the falling edge. `live` is set once STAGES
// falling edges have passed with mr low. Assumes mr is held across
// at least one falling edge when asserted.
module freeze_div_ctl #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic mr,
    input  logic en,
    output logic live,
    output logic frz
);
    logic [STAGES-1:0] rls_q;

    generate
        if (STAGES == 1) begin : g_one
            // Purpose: single release stage loads the inverted reset.
            always_ff @(negedge clk) begin
                rls_q <= mr ? 1'b0 : 1'b1;
            end
        end else begin : g_chain
            // Purpose: release chain shifts ones in while reset is low.
            always_ff @(negedge clk) begin
                if (mr) rls_q <= '0;
                else    rls_q <= {rls_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    // Purpose: capture the freeze request on the falling edge.
    always_ff @(negedge clk) begin
        if (mr) frz <= 1'b0;
        else    frz <= en;
    end

    assign live = rls_q[STAGES-1];

    // R9: the release chain only advances one stage per falling edge
    a_r9_live_needs_chain: assert property (@(negedge clk) disable iff (mr)
        $rose(live) |-> $past(rls_q[0]));
endmodule

// File: rtl/freeze_div_counter.sv
// Module: synchronous binary counter with clear and run enable.
// A carry-chain toggle form lets every bit change on the same rising edge.
// Assumes clr dominates run.
module freeze_div_counter #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         run,
    output logic [W-1:0] cnt
);
    logic [W-1:0] tgl;
    logic [W-1:0] nxt;

    assign tgl[0] = run;
    generate
        for (genvar i = 1; i < W; i++) begin : g_carry
            assign tgl[i] = tgl[i-1] & cnt[i-1];
        end
    endgenerate

    // Purpose: flip the bits whose lower neighbours are all ones.
    always_comb begin
        nxt = cnt ^ tgl;
    end

    // Purpose: register the count, with clear taking priority.
    always_ff @(posedge clk) begin
        if (clr) cnt <= '0;
        else     cnt <= nxt;
    end

    // R1: a running cycle advances the count by one
    a_r1_step: assert property (@(posedge clk) disable iff (clr)
        run |=> cnt == W'($past(cnt) + 1'b1));
    // R4: a stopped cycle keeps the count
    a_r4_hold: assert property (@(posedge clk) disable iff (clr)
        !run |=> $stable(cnt));
    // R6: clearing leaves zero
    a_r6_clear: assert property (@(posedge clk)
        clr |=> cnt == '0);
endmodule

// File: rtl/freeze_div.sv
// Module: top of the freezable /2 /4 /8 divider.
// Outputs come straight from counter bits. The counter runs when the
// release chain is complete and no freeze was captured at the last
// falling edge. Assumes mr and en change away from clock edges.
module freeze_div
    import freeze_div_pkg::*;
(
    input  logic clk,
    input  logic mr,
    input  logic en,
    output logic q0,
    output logic q1,
    output logic q2
);
    logic     live;
    logic     frz;
    logic     run;
    logic     clr;
    div_cnt_t cnt;

    freeze_div_ctl #(.STAGES(RLS_STAGES)) u_ctl (
        .clk  (clk),
        .mr   (mr),
        .en   (en),
        .live (live),
        .frz  (frz)
    );

    // Purpose: derive the counter's clear and run controls.
    always_comb begin
        clr = mr | ~live;
        run = live & ~frz;
    end

    freeze_div_counter #(.W(DIV_W)) u_cnt (
        .clk (clk),
        .clr (clr),
        .run (run),
        .cnt (cnt)
    );

    assign q0 = cnt[0];
    assign q1 = cnt[1];
    assign q2 = cnt[2];

    // R2: q1 only falls together with q0
    a_r2_q1_aligned: assert property (@(posedge clk) disable iff (mr)
        ($past(run) && !$past(mr) && $fell(q1)) |-> $fell(q0));
    // R2: q2 only falls together with q1
    a_r2_q2_aligned: assert property (@(posedge clk) disable iff (mr)
        ($past(run) && !$past(mr) && $fell(q2)) |-> $fell(q1));
    // R7 and R8: no count within two edges of a reset-high edge
    a_r7_no_early_count: assert property (@(posedge clk) disable iff (mr)
        $past(mr, 2) |-> (cnt == '0));
endmodule

// File: tb/tb_freeze_div.sv
module tb_freeze_div;
    logic clk = 1'b0;
    logic mr  = 1'b1;
    logic en  = 1'b0;
    logic q0, q1, q2;

    int checks = 0;
    int fails  = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    // behavioural reference state
    int negs_low = 0;
    bit frz_m    = 1'b0;
    int cnt_m    = 0;

    freeze_div dut (.clk(clk), .mr(mr), .en(en), .q0(q0), .q1(q1), .q2(q2));

    always #4 clk = ~clk;   // 125 MHz

    function automatic int qv();
        return {29'd0, q2, q1, q0};
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // reference: falling-edge view of reset and freeze
    always @(negedge clk) begin
        if (mr) begin negs_low = 0; frz_m = 1'b0; end
        else begin
            if (negs_low < 2) negs_low++;
            frz_m = en;
        end
    end

    // reference: rising-edge count
    always @(posedge clk) begin
        if (mr || negs_low < 2) cnt_m = 0;
        else if (!frz_m)        cnt_m = (cnt_m + 1) % 8;
    end

    // per-cycle comparison (R1 R3 R4 R5 R6 R9 via model)
    always @(posedge clk) begin
        #1;
        if (armed && !done) check("R1_model", qv(), cnt_m);
    end

    task automatic latency(input string req, input int exp_v);
        int lat = 0;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); #1;
            if (q0 && lat == 0) lat = k;
        end
        check(req, lat, exp_v);
    endtask

    task automatic period(input int bitn, input int exp_v, input string req);
        int n = 0;
        bit prev;
        prev = qv()[bitn];
        while (!(qv()[bitn] && !prev)) begin
            prev = qv()[bitn];
            @(posedge clk); #1;
        end
        prev = 1'b1;
        do begin
            @(posedge clk); #1; n++;
            if (qv()[bitn] && !prev) break;
            prev = qv()[bitn];
        end while (n < 20);
        check(req, n, exp_v);
    endtask

    initial begin
        int snap;
        repeat (3) @(posedge clk);
        #1;
        armed = 1'b1;
        check("R6_reset_state", qv(), 0);

        // R7: release while clk high
        @(posedge clk); #1; mr = 1'b0;
        latency("R7_release_high", 2);

        // R1 periods
        period(0, 2, "R1_q0_period");
        period(1, 4, "R1_q1_period");
        period(2, 8, "R1_q2_period");
        repeat (3) @(posedge clk);

        // R3 / R4 freeze
        @(posedge clk); #1; en = 1'b1; snap = qv();
        @(posedge clk); #1; check("R3_freeze_entry", qv(), snap);
        repeat (6) @(posedge clk);
        #1; check("R4_hold", qv(), snap);
        // R5 resume
        en = 1'b0;
        @(posedge clk); #1; check("R5_resume", qv(), (snap + 1) % 8);
        @(posedge clk); #1; check("R5_resume_next", qv(), (snap + 2) % 8);

        // R6 reset mid-count
        repeat (2) @(posedge clk);
        #1; mr = 1'b1;
        @(posedge clk); #1; check("R6_clear", qv(), 0);
        repeat (2) @(posedge clk);

        // R8: release while clk low
        @(negedge clk); #1; mr = 1'b0;
        latency("R8_release_low", 3);

        // R9: freeze held through release
        repeat (3) @(posedge clk);
        #1; mr = 1'b1; en = 1'b1;
        repeat (2) @(posedge clk);
        #1; mr = 1'b0;
        repeat (5) @(posedge clk);
        #1; check("R9_frozen_after_release", qv(), 0);
        en = 1'b0;
        @(posedge clk); #1; check("R9_first_count", qv(), 1);
        repeat (12) @(posedge clk);
        #2;
        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        done = 1'b1;
        finish_up();
    end
endmodule